// File: doc/BRIEF.md
# Banked Per-Line Interrupt Controller

This block gathers a set of interrupt request lines, organised as banks of 32, and presents them to a processor on two outputs: a normal request and a fast request. A 32-bit configuration word for each line sets three things: a 5-bit priority (0 is the most urgent), whether the line is edge- or level-sensitive, and which output the line is routed to. A per-bank mask register and a pending register are also provided. Software can inject an interrupt on any line. It can clear pending lines through the pending register.

Each output runs its own agreement cycle. While a path is armed and at least one unmasked pending line is routed to it, the controller picks a winner, latches that line's number in a code register, raises the output, and disarms the path. The output and the code stay frozen until software issues a new agreement through the control register. The handler learns which line fired by reading the code register. For an edge-sensitive line, that read also acknowledges the line and clears its pending bit.

Access is through a single-cycle register port. The port takes word accesses only. Read data is registered and appears the cycle after the request.

Top module: `banked_intc`

## Requirements
- R1: After reset both outputs are low and both paths are armed. Every pending bit, configuration word and code register reads 0, and every mask register reads 0xFFFFFFFF.
- R2: Address bit 8 and above select the bank, and bits [7:0] select the register within the bank: pending at 0x00, mask at 0x04, software injection at 0x9C, and the configuration word of line i at 0x1C+4*i. The normal code (0x10), the fast code (0x14) and control (0x18) exist only in bank 0. Any access with address bits [1:0] not zero, or to any other offset or bank, reads 0 and changes nothing.
- R3: A configuration word holds the priority in bits [6:2], level sensitivity in bit 1 (1 = level, 0 = edge) and fast routing in bit 0 (1 = fast output). It reads back with bits [31:7] zero.
- R4: An edge-sensitive line becomes pending only when its input goes from low to high. The bit stays pending after the input drops.
- R5: A level-sensitive line is pending in every cycle after one in which its input is high. It stops being pending in the cycle after its input falls.
- R6: A line competes on a path only when it is pending, unmasked and routed to that path. A masked line still shows in the pending register.
- R7: Among competing lines, the lowest priority value wins. When priorities are equal, the higher line number wins.
- R8: An armed path with a competing line raises its output one cycle after the line first competes, and latches the winner's number. The output and the code then stay unchanged until a new agreement is issued.
- R9: Writing control bit 0 issues a new agreement on the normal path, and bit 1 does the same on the fast path. The output drops on the next edge and the path re-arms.
- R10: Reading a code register returns the latched line number. If that line is edge-sensitive, the read clears its pending bit. A level-sensitive line is left pending.
- R11: A write to the pending register ANDs the written value into the bank's pending bits. A level-sensitive line whose input is high stays pending.
- R12: Each 1 written to the software injection register acts as a one-cycle assertion of that line. An edge-sensitive line whose input is already high gains nothing from it.
- R13: The mask register is read/write. A 1 blocks the line from both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (9) | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_lines | input | NBANKS*32 (64) | Interrupt inputs, active high |
| norm_irq | output | 1 | Normal-path request |
| fast_irq | output | 1 | Fast-path request |

## Verification
The bench targets the cases an arbiter gets wrong most easily. The first is a tie between equal priorities in different banks: a design with the wrong tie rule reports the lower line. The second is a priority contest: an inverted comparison picks the less urgent line. The bench also checks that reading the code register acknowledges edge lines but not level lines, and that a software clear cannot drop a level line whose input is still high. A design that got these wrong would either leave stale pending bits or lose a live level interrupt. Further cases are a masked line that must stay pending but silent until it is unmasked, injection on an edge line whose input is already high (which must produce nothing), and the rule that the output and code stay latched until a new agreement. Unmapped, misaligned and out-of-bank accesses are checked for reading zero and leaving the mask untouched.

// File: rtl/banked_intc_pkg.sv
// Package: shared constants, register offsets and line configuration type
// for the banked interrupt controller.
package banked_intc_pkg;

    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned PRIO_W         = 5;
    localparam int unsigned IDX_W          = 5;   // line index inside a bank

    // Register offsets within a bank's 256-byte window.
    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_NCODE = 8'h10;
    localparam logic [7:0] OFS_FCODE = 8'h14;
    localparam logic [7:0] OFS_CTRL  = 8'h18;
    localparam logic [7:0] OFS_CFG0  = 8'h1C;
    localparam logic [7:0] OFS_CFGN  = 8'h98;
    localparam logic [7:0] OFS_SWI   = 8'h9C;

    // Configuration word layout, packed to match bits [6:0] of the register.
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              fast;
    } line_cfg_t;

    localparam int unsigned CFG_W = $bits(line_cfg_t);

endpackage

// File: rtl/banked_intc_regdec.sv
// Module: banked_intc_regdec
// Purpose: decodes a register-port address into register hits for one bank
//          index. Purely combinational.
// Assumes: word accesses only; misaligned, unmapped or out-of-range bank
//          addresses produce no hit, and the global registers live in bank 0.
module banked_intc_regdec
    import banked_intc_pkg::*;
#(
    parameter int unsigned NBANKS = 2,
    parameter int unsigned BANK_W = 1,
    parameter int unsigned ADDR_W = 9
) (
    input  logic                  valid,
    input  logic [ADDR_W-1:0]     addr,
    output logic [BANK_W-1:0]     bank,
    output logic                  hit_pend,
    output logic                  hit_mask,
    output logic                  hit_ncode,
    output logic                  hit_fcode,
    output logic                  hit_ctrl,
    output logic                  hit_cfg,
    output logic                  hit_swi,
    output logic [IDX_W-1:0]      cfg_idx
);

    logic [7:0] ofs;
    logic       ok;
    logic       is_b0;

    // Split the address and qualify alignment and bank range.
    always_comb begin
        ofs   = addr[7:0];
        bank  = addr[ADDR_W-1:8];
        ok    = valid && (addr[1:0] == 2'b00) && (int'(bank) < int'(NBANKS));
        is_b0 = (bank == '0);
    end

    // Match the offset against the register map.
    always_comb begin
        hit_pend  = ok && (ofs == OFS_PEND);
        hit_mask  = ok && (ofs == OFS_MASK);
        hit_swi   = ok && (ofs == OFS_SWI);
        hit_ncode = ok && is_b0 && (ofs == OFS_NCODE);
        hit_fcode = ok && is_b0 && (ofs == OFS_FCODE);
        hit_ctrl  = ok && is_b0 && (ofs == OFS_CTRL);
        hit_cfg   = ok && (ofs >= OFS_CFG0) && (ofs <= OFS_CFGN);
        cfg_idx   = IDX_W'((ofs - OFS_CFG0) >> 2);
    end

endmodule

// File: rtl/banked_intc_bank.sv
// Module: banked_intc_bank
// Purpose: holds the state of 32 lines: input history, pending bits, mask
//          bits and per-line configuration. Applies edge or level capture,
//          software injection, software clear and acknowledge.
// Assumes: irq_in is synchronous to clk; at most one register strobe per cycle.
module banked_intc_bank
    import banked_intc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LINES_PER_BANK-1:0]        irq_in,
    input  logic                             pend_wr,
    input  logic                             mask_wr,
    input  logic                             swi_wr,
    input  logic                             cfg_wr,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [31:0]                      wdata,
    input  logic [LINES_PER_BANK-1:0]        ack,
    output logic [LINES_PER_BANK-1:0]        pend_o,
    output logic [LINES_PER_BANK-1:0]        mask_o,
    output logic [LINES_PER_BANK-1:0]        level_o,
    output logic [LINES_PER_BANK-1:0]        fast_o,
    output line_cfg_t [LINES_PER_BANK-1:0]   cfg_o
);

    localparam int unsigned L = LINES_PER_BANK;

    logic [L-1:0] prev_q, pend_q, mask_q;
    line_cfg_t [L-1:0] cfg_q;
    logic [L-1:0] lvl, rise, fall, inj, set_v, keep_v, pend_d;

    // Unpack level and routing bits from the configuration array.
    for (genvar g = 0; g < L; g++) begin : g_unpack
        assign lvl[g]     = cfg_q[g].level;
        assign fast_o[g]  = cfg_q[g].fast;
    end

    // Compute the events and the next pending vector.
    always_comb begin
        rise   = irq_in & ~prev_q;
        fall   = prev_q & ~irq_in;
        inj    = swi_wr ? wdata : '0;
        set_v  = (~lvl & (rise | (inj & ~irq_in))) | (lvl & (irq_in | inj));
        keep_v = pend_wr ? (wdata | (lvl & irq_in)) : '1;
        pend_d = (pend_q & keep_v & ~(ack & ~lvl) & ~(lvl & fall)) | set_v;
    end

    // Register input history, pending and mask state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            prev_q <= irq_in;
            pend_q <= pend_d;
            if (mask_wr) mask_q <= wdata;
        end
    end

    // Register the per-line configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q[cfg_idx] <= line_cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign level_o = lvl;
    assign cfg_o   = cfg_q;

    // R5
    level_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(lvl & irq_in)) |=> ((pend_q & $past(lvl & irq_in)) == $past(lvl & irq_in)));

    // R13
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/banked_intc_path.sv
// Module: banked_intc_path
// Purpose: one output path. Selects the most urgent competing line, latches
//          its number and drives the request until a new agreement re-arms it.
// Assumes: priority 0 is the most urgent; ties go to the higher line number.
module banked_intc_path
    import banked_intc_pkg::*;
#(
    parameter int unsigned NLINES  = 64,
    parameter bit          IS_FAST = 1'b0,
    parameter int unsigned LINE_W  = $clog2(NLINES)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NLINES-1:0]                  pend,
    input  logic [NLINES-1:0]                  mask,
    input  logic [NLINES-1:0]                  fast,
    input  logic [NLINES-1:0][PRIO_W-1:0]      prio,
    input  logic                               rearm,
    output logic                               irq_o,
    output logic [LINE_W-1:0]                  code_o
);

    logic [NLINES-1:0] route, elig;
    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [LINE_W-1:0] best_i;
    logic              armed_q, irq_q;
    logic [LINE_W-1:0] code_q;

    // Pick the routing polarity for this path.
    if (IS_FAST) begin : g_fast
        assign route = fast;
    end else begin : g_norm
        assign route = ~fast;
    end

    assign elig = pend & ~mask & route;

    // Scan upward so an equal priority at a higher index replaces the holder.
    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        for (int i = 0; i < int'(NLINES); i++) begin
            if (elig[i] && (!found || (prio[i] <= best_p))) begin
                found  = 1'b1;
                best_p = prio[i];
                best_i = LINE_W'(i);
            end
        end
    end

    // Agreement state: re-arm on request, fire once when armed and a line competes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
            code_q  <= '0;
        end else if (rearm) begin
            armed_q <= 1'b1;
            irq_q   <= 1'b0;
        end else if (armed_q && found) begin
            armed_q <= 1'b0;
            irq_q   <= 1'b1;
            code_q  <= best_i;
        end
    end

    assign irq_o  = irq_q;
    assign code_o = code_q;

    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm |=> !irq_o);

    // R8
    fire_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(found));

    // R8
    code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_q) && irq_q) |-> $stable(code_o));

endmodule

// File: rtl/banked_intc.sv
// Module: banked_intc
// Purpose: top of the banked interrupt controller. Decodes the register
//          port, instantiates one state block per bank and one arbiter per
//          output, forms acknowledges from code reads and registers read data.
// Assumes: single-cycle word accesses; read data appears one cycle later.
module banked_intc
    import banked_intc_pkg::*;
#(
    parameter int unsigned NBANKS = 2,
    parameter int unsigned NLINES = NBANKS * LINES_PER_BANK,
    parameter int unsigned LINE_W = $clog2(NLINES),
    parameter int unsigned BANK_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
    parameter int unsigned ADDR_W = 8 + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic [31:0]        rsp_rdata,
    input  logic [NLINES-1:0]  irq_lines,
    output logic               norm_irq,
    output logic               fast_irq
);

    logic [BANK_W-1:0] bank;
    logic hit_pend, hit_mask, hit_ncode, hit_fcode, hit_ctrl, hit_cfg, hit_swi;
    logic [IDX_W-1:0] cfg_idx;
    logic wr, rd;

    logic [NLINES-1:0]              pend_all, mask_all, level_all, fast_all, ack_all;
    logic [NLINES-1:0][PRIO_W-1:0]  prio_all;
    line_cfg_t [NLINES-1:0]         cfg_all;
    logic [LINE_W-1:0]              ncode, fcode;
    logic                           rearm_n, rearm_f;
    logic [31:0]                    rdata_d;

    banked_intc_regdec #(
        .NBANKS (NBANKS),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .valid     (req_valid),
        .addr      (req_addr),
        .bank      (bank),
        .hit_pend  (hit_pend),
        .hit_mask  (hit_mask),
        .hit_ncode (hit_ncode),
        .hit_fcode (hit_fcode),
        .hit_ctrl  (hit_ctrl),
        .hit_cfg   (hit_cfg),
        .hit_swi   (hit_swi),
        .cfg_idx   (cfg_idx)
    );

    assign wr = req_write;
    assign rd = !req_write;

    // One state block per bank; write strobes are qualified by bank index.
    for (genvar b = 0; b < int'(NBANKS); b++) begin : g_bank
        logic sel;
        assign sel = (bank == BANK_W'(b));

        banked_intc_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_in  (irq_lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .pend_wr (wr && sel && hit_pend),
            .mask_wr (wr && sel && hit_mask),
            .swi_wr  (wr && sel && hit_swi),
            .cfg_wr  (wr && sel && hit_cfg),
            .cfg_idx (cfg_idx),
            .wdata   (req_wdata),
            .ack     (ack_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .pend_o  (pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .mask_o  (mask_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .level_o (level_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .fast_o  (fast_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .cfg_o   (cfg_all[b*LINES_PER_BANK +: LINES_PER_BANK])
        );
    end

    // Extract the priority field of every line for the arbiters.
    for (genvar g = 0; g < int'(NLINES); g++) begin : g_prio
        assign prio_all[g] = cfg_all[g].prio;
    end

    assign rearm_n = req_valid && wr && hit_ctrl && req_wdata[0];
    assign rearm_f = req_valid && wr && hit_ctrl && req_wdata[1];

    banked_intc_path #(.NLINES(NLINES), .IS_FAST(1'b0), .LINE_W(LINE_W)) u_norm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_all),
        .mask   (mask_all),
        .fast   (fast_all),
        .prio   (prio_all),
        .rearm  (rearm_n),
        .irq_o  (norm_irq),
        .code_o (ncode)
    );

    banked_intc_path #(.NLINES(NLINES), .IS_FAST(1'b1), .LINE_W(LINE_W)) u_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_all),
        .mask   (mask_all),
        .fast   (fast_all),
        .prio   (prio_all),
        .rearm  (rearm_f),
        .irq_o  (fast_irq),
        .code_o (fcode)
    );

    // Acknowledge the latched line of a code read when it is edge-sensitive.
    always_comb begin
        ack_all = '0;
        if (rd && hit_ncode) ack_all[ncode] = ~level_all[ncode];
        if (rd && hit_fcode) ack_all[fcode] = ~level_all[fcode];
    end

    // Select read data for the addressed register.
    always_comb begin
        rdata_d = '0;
        for (int b = 0; b < int'(NBANKS); b++) begin
            if (bank == BANK_W'(b)) begin
                if (hit_pend) rdata_d = pend_all[b*LINES_PER_BANK +: LINES_PER_BANK];
                if (hit_mask) rdata_d = mask_all[b*LINES_PER_BANK +: LINES_PER_BANK];
                if (hit_cfg)  rdata_d = 32'(cfg_all[b*LINES_PER_BANK + int'(cfg_idx)]);
            end
        end
        if (hit_ncode) rdata_d = 32'(ncode);
        if (hit_fcode) rdata_d = 32'(fcode);
    end

    // Register read data one cycle after a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (req_valid && rd) begin
            rsp_rdata <= rdata_d;
        end
    end

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_all));

    // R10
    ack_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_all & level_all) == '0);

endmodule

// File: tb/banked_intc_tb.sv
`timescale 1ns/1ps
module banked_intc_tb;

    localparam int NL = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [NL-1:0] irq_lines = '0;
    logic        norm_irq, fast_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_q = 1'b0;

    always #2.5 clk = ~clk;

    banked_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq_lines (irq_lines),
        .norm_irq  (norm_irq),
        .fast_irq  (fast_irq)
    );

    // Monitor: note read issue at the edge, compare half a cycle later.
    always @(posedge clk) rd_q <= req_valid && !req_write;

    always @(negedge clk) begin
        if (rd_q) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rsp_rdata !== e) begin
                errors++;
                $display("FAIL %s: read got %08h expected %08h", t, rsp_rdata, e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pin(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: pin got %0b expected %0b", t, act, e);
        end
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        pin(norm_irq, 1'b0, "R1 norm low");
        pin(fast_irq, 1'b0, "R1 fast low");
        rd(9'h004, 32'hFFFF_FFFF, "R1 mask bank0");
        rd(9'h104, 32'hFFFF_FFFF, "R1 mask bank1");
        rd(9'h000, 32'h0, "R1 pending");
        rd(9'h028, 32'h0, "R1 cfg");
        // R13 unmask everything
        wr(9'h004, 32'h0);
        wr(9'h104, 32'h0);
        rd(9'h104, 32'h0, "R13 mask readback");
        // R4 R8 edge line 5
        irq_lines[5] = 1'b1;
        step(); step();
        pin(norm_irq, 1'b1, "R8 norm fires");
        rd(9'h010, 32'd5, "R10 code 5");
        rd(9'h000, 32'h0, "R10 edge acked");
        irq_lines[5] = 1'b0;
        step();
        pin(norm_irq, 1'b1, "R8 output latched");
        // R9 new normal agreement
        wr(9'h018, 32'h1);
        pin(norm_irq, 1'b0, "R9 norm drops");
        step();
        pin(norm_irq, 1'b0, "R9 nothing pending");
        // R7 tie across banks
        irq_lines[3] = 1'b1; irq_lines[40] = 1'b1;
        step(); step();
        pin(norm_irq, 1'b1, "R7 tie fires");
        rd(9'h010, 32'd40, "R7 tie higher index");
        irq_lines[3] = 1'b0; irq_lines[40] = 1'b0;
        step();
        rd(9'h000, 32'h8, "R4 edge stays after drop");
        // R3 R7 priority contest
        wr(9'h028, 32'h1C);
        wr(9'h06C, 32'h08);
        rd(9'h028, 32'h1C, "R3 cfg readback");
        irq_lines[20] = 1'b1;
        step();
        wr(9'h018, 32'h1);
        pin(norm_irq, 1'b0, "R9 rearm");
        step();
        pin(norm_irq, 1'b1, "R8 refire");
        rd(9'h010, 32'd20, "R7 lower value wins");
        irq_lines[20] = 1'b0;
        // R11 software clear of edge line
        wr(9'h000, ~32'h8);
        rd(9'h000, 32'h0, "R11 AND clear");
        // R5 R11 R10 level line 6
        wr(9'h034, 32'h2);
        irq_lines[6] = 1'b1;
        step();
        wr(9'h000, 32'h0);
        rd(9'h000, 32'h40, "R11 level held");
        wr(9'h018, 32'h1);
        step();
        rd(9'h010, 32'd6, "R10 level code");
        rd(9'h000, 32'h40, "R10 level not acked");
        irq_lines[6] = 1'b0;
        step();
        rd(9'h000, 32'h0, "R5 level clears on drop");
        // R6 fast routing, line 33
        wr(9'h120, 32'h1);
        irq_lines[33] = 1'b1;
        step(); step();
        pin(fast_irq, 1'b1, "R6 fast fires");
        pin(norm_irq, 1'b1, "R8 norm unchanged");
        rd(9'h014, 32'd33, "R10 fast code");
        rd(9'h100, 32'h0, "R10 fast acked");
        irq_lines[33] = 1'b0;
        wr(9'h018, 32'h2);
        pin(fast_irq, 1'b0, "R9 fast drops");
        pin(norm_irq, 1'b1, "R9 norm untouched");
        // R6 R13 masking line 50
        wr(9'h104, 32'h0004_0000);
        irq_lines[50] = 1'b1;
        step();
        wr(9'h018, 32'h1);
        step();
        pin(norm_irq, 1'b0, "R6 masked silent");
        rd(9'h100, 32'h0004_0000, "R6 masked visible");
        wr(9'h104, 32'h0);
        step();
        pin(norm_irq, 1'b1, "R13 unmask fires");
        rd(9'h010, 32'd50, "R13 code 50");
        irq_lines[50] = 1'b0;
        // R12 software injection
        wr(9'h09C, 32'h800);
        wr(9'h018, 32'h1);
        pin(norm_irq, 1'b0, "R12 rearm");
        step();
        pin(norm_irq, 1'b1, "R12 injected fires");
        rd(9'h010, 32'd11, "R12 code 11");
        irq_lines[13] = 1'b1;
        step();
        rd(9'h000, 32'h2000, "R4 rise pends");
        wr(9'h000, 32'h0);
        wr(9'h09C, 32'h2000);
        rd(9'h000, 32'h0, "R12 no new edge");
        irq_lines[13] = 1'b0;
        // R2 map corners
        wr(9'h00C, 32'h1234);
        rd(9'h00C, 32'h0, "R2 unmapped");
        rd(9'h110, 32'h0, "R2 code only bank0");
        wr(9'h005, 32'hFFFF_FFFF);
        rd(9'h004, 32'h0, "R2 misaligned ignored");
        rd(9'h120, 32'h1, "R3 bank1 cfg");
        repeat (3) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule